// File: doc/BRIEF.md
# Quad Reloadable Down-Counter Timer Bank

This block holds four 8-bit down-counting timers. Each timer has a reload register, and the four timers sit at four consecutive byte offsets of a simple processor bus. A bus write to one offset puts the same byte into that timer's reload register and into its live counter. After that, the counter steps down by one on every clock cycle in which its count-enable input is high.

When an enabled count finds the counter at zero, the counter does not wrap to all ones. It takes the reload value instead, and the timer's overflow output goes high for one clock. A bus read returns the live counter value combinationally, in the same cycle as the read. The reload register cannot be read back. Its effect shows only in the value the counter takes at each reload.

The enable pulses come from count sources outside this block. The overflow outputs go to whatever logic uses them.

Top module: `quad_timer_bank`

## Requirements
- R1: While reset is asserted and after it is released, every counter and every reload register holds 0xFF and all overflow outputs are low.
- R2: A write with `bus_sel`=1 and `bus_wr`=1 stores `bus_wdata` into both the reload register and the counter of the addressed timer. Every other timer is left unchanged.
- R3: When `bus_sel`=1 and `bus_rd`=1, `bus_rdata` shows the addressed timer's live counter value in the same cycle. Otherwise `bus_rdata` is 0x00.
- R4: In a cycle where `cnt_en[i]`=1 and no write hits timer i, a nonzero counter decreases by exactly one at the clock edge. When `cnt_en[i]`=0, the counter holds its value.
- R5: An enabled count on a counter at 0x00 loads the counter from its reload register. `ovf[i]` is then high for exactly the one cycle after that clock edge. `ovf[i]` is low after every other kind of edge.
- R6: Counting and reloading never change a reload register. Only a write does.
- R7: When a write and a count enable hit the same timer in the same cycle, the write takes effect, the count is dropped, and no overflow is raised.
- R8: With a reload value N, overflows occur every N+1 enabled counts. A reload value of 0x00 gives an overflow on every enabled count.
- R9: Offsets 0, 1, 2 and 3 select timers 1, 2, 3 and 4 (bit 0, 1, 2 and 3 of `cnt_en` and `ovf`). A write with `bus_sel`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Selects the timer bank for this access |
| bus_addr | input | 2 | Timer offset within the bank |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Live counter of the addressed timer, combinational |
| cnt_en | input | 4 | One count-enable pulse input per timer |
| ovf | output | 4 | One-cycle overflow flag per timer |

## Verification
Read data is combinational, so the bench compares `bus_rdata` a short delay after it drives the inputs, before the next rising edge. Writes, counts and reloads take effect at the next rising edge. The bench therefore moves its reference model forward at that edge and compares `ovf` shortly after the edge, at the point where the registered flag for that edge is valid. Counter contents are checked only through bus reads, so write-over-count, reload values and period lengths are all observed at the ports.

// File: rtl/tmrbank_pkg.sv
package tmrbank_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOAD   = 2'd1,
        ACT_DEC    = 2'd2,
        ACT_RELOAD = 2'd3
    } chan_act_e;

    // A bus write takes priority over a count in the same cycle.
    function automatic chan_act_e pick_action(input logic wr_hit,
                                              input logic en,
                                              input logic at_zero);
        if (wr_hit)
            return ACT_LOAD;
        else if (en && at_zero)
            return ACT_RELOAD;
        else if (en)
            return ACT_DEC;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/tmrbank_chan.sv
module tmrbank_chan #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wdata,
    input  logic         cnt_en,
    output logic [W-1:0] cnt_o,
    output logic         ovf_o
);
    import tmrbank_pkg::*;

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] lat;
        logic [W-1:0] cnt;
        logic         ovf;
    } chan_t;

    chan_t     s_d, s_q;
    chan_act_e act_d;

    always_comb begin
        s_d     = s_q;
        s_d.ovf = 1'b0;
        act_d   = pick_action(wr_hit, cnt_en, s_q.cnt == ZERO);
        unique case (act_d)
            ACT_LOAD: begin
                s_d.lat = wdata;
                s_d.cnt = wdata;
            end
            ACT_RELOAD: begin
                s_d.cnt = s_q.lat;
                s_d.ovf = 1'b1;
            end
            ACT_DEC: begin
                s_d.cnt = s_q.cnt - ONE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.lat <= RST_VAL;
            s_q.cnt <= RST_VAL;
            s_q.ovf <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;
    assign ovf_o = s_q.ovf;

    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (cnt_o == $past(wdata)) && !ovf_o);

    a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && cnt_en && cnt_o != ZERO) |=> (cnt_o == $past(cnt_o) - ONE) && !ovf_o);

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !cnt_en) |=> $stable(cnt_o) && !ovf_o);

    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && cnt_en && cnt_o == ZERO) |=> ovf_o && (cnt_o == s_q.lat));

    a_r6_latch_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(s_q.lat));

endmodule

// File: rtl/tmrbank_decode.sv
module tmrbank_decode #(
    parameter int N  = 4,
    parameter int W  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic [AW-1:0]       addr,
    input  logic                wr,
    input  logic                rd,
    input  logic [N-1:0][W-1:0] cnt_vec,
    output logic [N-1:0]        wr_vec,
    output logic [W-1:0]        rdata
);
    logic access_wr;
    logic access_rd;

    assign access_wr = sel && wr;
    assign access_rd = sel && rd;

    for (genvar gi = 0; gi < N; gi++) begin : g_wr
        assign wr_vec[gi] = access_wr && (addr == AW'(gi));
    end

    always_comb begin
        rdata = '0;
        if (access_rd) begin
            for (int i = 0; i < N; i++) begin
                if (addr == AW'(i))
                    rdata = cnt_vec[i];
            end
        end
    end

    a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));

    a_r9_no_sel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (wr_vec == '0));

    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && rd) |-> (rdata == '0));

endmodule

// File: rtl/quad_timer_bank.sv
module quad_timer_bank #(
    parameter int N  = 4,
    parameter int W  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [N-1:0]  cnt_en,
    output logic [N-1:0]  ovf
);
    localparam logic [W-1:0] RST_VAL = '1;

    logic [N-1:0][W-1:0] cnt_vec;
    logic [N-1:0]        wr_vec;

    tmrbank_decode #(.N(N), .W(W), .AW(AW)) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (bus_sel),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .cnt_vec (cnt_vec),
        .wr_vec  (wr_vec),
        .rdata   (bus_rdata)
    );

    for (genvar gi = 0; gi < N; gi++) begin : g_chan
        tmrbank_chan #(.W(W), .RST_VAL(RST_VAL)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (wr_vec[gi]),
            .wdata  (bus_wdata),
            .cnt_en (cnt_en[gi]),
            .cnt_o  (cnt_vec[gi]),
            .ovf_o  (ovf[gi])
        );
    end

    a_r1_no_ovf_after_reset: assert property (@(posedge clk)
        !rst_n |=> (ovf == '0));

    a_r1_reset_count: assert property (@(posedge clk)
        !rst_n |=> !(bus_sel && bus_rd) || (bus_rdata == RST_VAL));

endmodule

// File: tb/tb_quad_timer_bank.sv
`timescale 1ns/1ps
module tb_quad_timer_bank;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_sel, bus_wr, bus_rd;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [3:0] cnt_en;
    logic [3:0] ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] m_cnt [4];
    logic [7:0] m_lat [4];
    logic [3:0] m_ovf;

    always #5 clk = ~clk;

    quad_timer_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cnt_en(cnt_en), .ovf(ovf)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic s, input logic r, input logic [1:0] a);
        return (s && r) ? m_cnt[a] : 8'h00;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_cnt[i] = 8'hFF;
            m_lat[i] = 8'hFF;
        end
        m_ovf = '0;
    endtask

    task automatic model_step(input logic s, input logic w, input logic [1:0] a,
                              input logic [7:0] d, input logic [3:0] e);
        for (int i = 0; i < 4; i++) begin
            m_ovf[i] = 1'b0;
            if (s && w && a == 2'(i)) begin
                m_cnt[i] = d;
                m_lat[i] = d;
            end else if (e[i]) begin
                if (m_cnt[i] == 8'h00) begin
                    m_cnt[i] = m_lat[i];
                    m_ovf[i] = 1'b1;
                end else begin
                    m_cnt[i] = m_cnt[i] - 8'd1;
                end
            end
        end
    endtask

    // One bus cycle: drive at the falling edge, check read data before the
    // rising edge, check overflow flags just after it.
    task automatic cyc(input string tag, input logic s, input logic w, input logic r,
                       input logic [1:0] a, input logic [7:0] d, input logic [3:0] e);
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; cnt_en = e;
        #1;
        chk({tag, " rdata"}, bus_rdata, exp_read(s, r, a));
        model_step(s, w, a, d, e);
        @(posedge clk);
        #1;
        chk({tag, " ovf"}, {4'h0, ovf}, {4'h0, m_ovf});
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < 4; i++) cyc(tag, 1, 0, 1, 2'(i), 8'h00, 4'h0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0;
        bus_wdata = 0; cnt_en = 0;
        model_reset();
        repeat (3) @(posedge clk);
        // R1: reset values visible during reset
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = 2'd2;
        #1;
        chk("R1 rdata in reset", bus_rdata, 8'hFF);
        chk("R1 ovf in reset", {4'h0, ovf}, 8'h00);
        bus_sel = 0; bus_rd = 0;
        @(negedge clk);
        rst_n = 1;
        rd_all("R1");

        // R9/R2: offset 2 is timer 3 only
        cyc("R2", 1, 1, 0, 2'd2, 8'h05, 4'h0);
        rd_all("R9");
        chk("R2 timer3 value", m_cnt[2], 8'h05);
        // R9: write without select ignored
        cyc("R9", 0, 1, 0, 2'd1, 8'h33, 4'h0);
        cyc("R9", 1, 0, 1, 2'd1, 8'h00, 4'h0);

        // R4: count with gaps
        cyc("R4", 0, 0, 0, 2'd0, 8'h00, 4'b0100);
        cyc("R4", 0, 0, 0, 2'd0, 8'h00, 4'b0000);
        cyc("R4", 0, 0, 0, 2'd0, 8'h00, 4'b0100);
        cyc("R4", 0, 0, 0, 2'd0, 8'h00, 4'b0100);
        cyc("R4", 1, 0, 1, 2'd2, 8'h00, 4'h0);
        chk("R4 model 2", m_cnt[2], 8'h02);
        // R5/R6: run to zero then reload
        cyc("R5", 0, 0, 0, 2'd0, 8'h00, 4'b0100);
        cyc("R5", 0, 0, 0, 2'd0, 8'h00, 4'b0100);
        cyc("R5", 0, 0, 0, 2'd0, 8'h00, 4'b0100);
        chk("R5 ovf timer3", {7'h0, ovf[2]}, 8'h01);
        cyc("R5", 0, 0, 0, 2'd0, 8'h00, 4'b0000);
        chk("R5 ovf one cycle", {7'h0, ovf[2]}, 8'h00);
        cyc("R6", 1, 0, 1, 2'd2, 8'h00, 4'h0);

        // R8: reload 0 overflows each pulse
        cyc("R8", 1, 1, 0, 2'd0, 8'h00, 4'h0);
        for (int k = 0; k < 3; k++) begin
            cyc("R8", 0, 0, 0, 2'd0, 8'h00, 4'b0001);
            chk("R8 zero reload ovf", {7'h0, ovf[0]}, 8'h01);
        end
        // R8: reload 3 gives period 4
        cyc("R8", 1, 1, 0, 2'd1, 8'h03, 4'h0);
        for (int p = 0; p < 2; p++) begin
            int n = 0;
            bit seen = 0;
            while (!seen && n < 10) begin
                cyc("R8", 0, 0, 0, 2'd0, 8'h00, 4'b0010);
                n++;
                seen = ovf[1];
            end
            chk("R8 period", 8'(n), 8'd4);
        end

        // R7: write and count collide at zero
        cyc("R7", 1, 1, 0, 2'd3, 8'h00, 4'h0);
        cyc("R7", 1, 1, 0, 2'd3, 8'h09, 4'b1000);
        chk("R7 no ovf", {7'h0, ovf[3]}, 8'h00);
        cyc("R7", 1, 0, 1, 2'd3, 8'h00, 4'h0);

        // R1/R6: reset reload value is 0xFF, shown after 256 counts
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        for (int k = 0; k < 256; k++) cyc("R1", 0, 0, 0, 2'd0, 8'h00, 4'b1000);
        chk("R1 reset reload ovf", {7'h0, ovf[3]}, 8'h01);
        cyc("R1", 1, 0, 1, 2'd3, 8'h00, 4'h0);

        // Random mix, R3/R5
        for (int k = 0; k < 4000; k++) begin
            logic       s, w, r;
            logic [7:0] d;
            s = ($urandom % 8) != 0;
            w = ($urandom % 6) == 0;
            r = ($urandom % 2) == 0;
            d = ($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 4);
            cyc("R3/R5 random", s, w, r, 2'($urandom), d, 4'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule